// File: doc/BRIEF.md
# Rotating Priority Bus Arbiter

This block decides which of several bus masters owns a shared bus. Each master has its own request line and gets its own grant line back. The arbiter hands the bus to a master only when the bus-busy input is low. That input may be held high by a default owner or by any agent that is not arbitrated here. The winner keeps its grant for as long as it holds its request. The grant is withdrawn on the clock edge where that request is seen low.

The priority order is chosen at run time. In fixed mode the lowest-numbered master always wins. In rotating mode, the master that was just served becomes the lowest-priority master when it releases the bus, and the master numbered after it becomes the highest. The mode input is latched only while the bus is idle, so the order cannot change in the middle of a tenure.

Top module: `rr_bus_arbiter`

## Requirements
- R1: After reset no grant is driven, the latched mode is fixed, and the rotation order starts with master 0 as highest priority, then 1, 2, up to NUM_MASTERS-1.
- R2: At most one bit of `grant` is high in any cycle.
- R3: A new grant is issued only at a clock edge where no grant is active, `bus_busy` is low, and at least one request is high. The grant is visible right after that edge. While `bus_busy` is high, no new grant is issued.
- R4: In fixed mode (latched mode 0) the requesting master with the lowest index wins.
- R5: In rotating mode (latched mode 1) the search starts at the rotation pointer. When master k releases the bus, the pointer moves to k+1, wrapping to 0 after the last master, so master k then has the lowest priority.
- R6: A grant is held while its owner keeps its request high, whatever the other requests do. It clears at the first edge where the owner's request is low. No new grant is issued at that same edge.
- R7: While no request is pending, no grant is driven and the rotation pointer keeps its value.
- R8: `mode_rotate` is sampled only at edges with no active grant and `bus_busy` low. Changes at other times are ignored. The latched value governs arbitration from the next edge on, and it also governs the pointer update at release.
- R9: A release in fixed mode leaves the rotation pointer unchanged. A later switch back to rotating mode resumes from where the pointer stood.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | NUM_MASTERS | Request line, one per master |
| bus_busy | input | 1 | High while the bus is in use by an unarbitrated agent |
| mode_rotate | input | 1 | 0 selects fixed priority, 1 selects rotating priority |
| grant | output | NUM_MASTERS | Grant line, one-hot or zero |

## Verification
The bench uses the default of four masters. With four masters, a full wrap of the rotation pointer takes only four releases, so directed sequences reach the wrap from the last master back to master 0. They also reach a pointer left behind by a stretch in fixed mode, and a mode change attempted during a tenure. A random phase then drives requests, bus-busy and mode together for several hundred cycles. A behavioural model with integer owner and pointer variables follows the same inputs, and the grant is compared against it every cycle.

// File: rtl/rr_bus_arbiter.sv
module rr_bus_arbiter #(
  parameter int NUM_MASTERS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MASTERS-1:0] req,
  input  logic                   bus_busy,
  input  logic                   mode_rotate,
  output logic [NUM_MASTERS-1:0] grant
);

  localparam int IW = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;

  logic [IW-1:0] owner;
  logic [IW-1:0] ptr;
  logic          mode_q;
  logic [IW-1:0] base;
  logic [IW-1:0] pick;
  logic          pick_vld;
  logic [IW-1:0] owner_next;
  logic          held;

  assign held       = |grant;
  assign base       = mode_q ? ptr : '0;
  assign owner_next = (owner == IW'(NUM_MASTERS - 1)) ? '0 : owner + 1'b1;

  always_comb begin
    logic [IW:0] idx;
    pick_vld = 1'b0;
    pick     = '0;
    for (int k = 0; k < NUM_MASTERS; k++) begin
      idx = {1'b0, base} + (IW+1)'(k);
      if (idx >= (IW+1)'(NUM_MASTERS)) idx = idx - (IW+1)'(NUM_MASTERS);
      if (!pick_vld && req[idx[IW-1:0]]) begin
        pick_vld = 1'b1;
        pick     = idx[IW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant  <= '0;
      owner  <= '0;
      ptr    <= '0;
      mode_q <= 1'b0;
    end else if (held) begin
      if (!req[owner]) begin
        grant <= '0;
        if (mode_q) ptr <= owner_next;
      end
    end else if (!bus_busy) begin
      mode_q <= mode_rotate;
      if (pick_vld) begin
        grant <= NUM_MASTERS'(1) << pick;
        owner <= pick;
      end
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R2

  AST_GRANT_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !$past(held)) |-> (!$past(bus_busy) && |($past(req) & grant))); // R3

  AST_HOLD_WHILE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (|(grant & req)) |=> $stable(grant)); // R6

  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!held && req == '0) |=> (grant == '0 && $stable(ptr))); // R7

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> $stable(mode_q)); // R8

  AST_FIXED_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |=> $stable(ptr)); // R9

endmodule

// File: tb/test_rr_bus_arbiter.sv
module test_rr_bus_arbiter;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic         bus_busy = 1'b0;
  logic         mode_rotate = 1'b0;
  logic [N-1:0] grant;

  int checks = 0;
  int fails  = 0;

  int m_owner = -1;
  int m_ptr   = 0;
  int m_mode  = 0;

  always #5 clk = ~clk;

  rr_bus_arbiter #(.NUM_MASTERS(N)) i_rr_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .bus_busy(bus_busy),
    .mode_rotate(mode_rotate), .grant(grant)
  );

  function automatic logic [N-1:0] model_grant();
    return (m_owner < 0) ? '0 : (N'(1) << m_owner);
  endfunction

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: grant=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    if (m_owner >= 0) begin
      if (!req[m_owner]) begin
        if (m_mode == 1) m_ptr = (m_owner + 1) % N;
        m_owner = -1;
      end
    end else if (!bus_busy) begin
      int b;
      b = (m_mode == 1) ? m_ptr : 0;
      for (int k = 0; k < N; k++) begin
        if (m_owner < 0 && req[(b + k) % N]) m_owner = (b + k) % N;
      end
      m_mode = mode_rotate;
    end
  endtask

  task automatic cyc(input logic [N-1:0] r, input logic b, input logic m, input string tag);
    req = r; bus_busy = b; mode_rotate = m;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag, grant, model_grant());
    checks++;
    if ($countones(grant) > 1) begin
      fails++;
      $display("FAIL R2: grant=%b expected at most one bit", grant);
    end
  endtask

  initial begin
    #2ms;
    fails++;
    $display("FAIL watchdog: run hung, grant=%b expected completion", grant);
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", grant, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", grant, '0);

    cyc(4'b1111, 0, 0, "R4 fixed lowest wins");
    check("R4 master0", grant, 4'b0001);
    repeat (3) cyc(4'b1111, 0, 0, "R6 hold");
    check("R6 held", grant, 4'b0001);
    cyc(4'b1110, 0, 0, "R6 release");
    check("R6 cleared at release", grant, 4'b0000);
    cyc(4'b1110, 0, 0, "R4 next fixed");
    check("R4 master1", grant, 4'b0010);
    cyc(4'b1111, 0, 0, "R6 other request ignored");
    check("R6 master0 ignored", grant, 4'b0010);
    cyc(4'b1101, 0, 0, "R6 release");
    cyc(4'b1101, 1, 0, "R3 busy blocks");
    check("R3 no grant while busy", grant, 4'b0000);
    cyc(4'b1101, 1, 0, "R3 busy blocks");
    cyc(4'b1101, 0, 0, "R3 free grants");
    check("R3 grant after free", grant, 4'b0001);
    cyc(4'b0000, 0, 0, "R9 fixed release");

    cyc(4'b0000, 0, 1, "R8 mode latched idle");
    cyc(4'b1001, 0, 1, "R9 pointer kept at 0");
    check("R9 master0 first", grant, 4'b0001);
    cyc(4'b1000, 0, 1, "R5 release rotates");
    cyc(4'b1001, 0, 1, "R5 rotated pick");
    check("R5 master3 over master0", grant, 4'b1000);
    cyc(4'b0000, 0, 1, "R5 wrap release");
    repeat (5) cyc(4'b0000, 0, 1, "R7 idle");
    check("R7 no grant idle", grant, 4'b0000);
    cyc(4'b1111, 0, 1, "R7 pointer unchanged");
    check("R5 wrapped to master0", grant, 4'b0001);
    cyc(4'b1111, 0, 0, "R8 mode ignored while granted");
    cyc(4'b1110, 0, 0, "R8 release uses latched mode");
    cyc(4'b1110, 0, 0, "R8 old mode still applies");
    check("R5 master1 after master0", grant, 4'b0010);
    cyc(4'b1100, 0, 0, "R9 fixed release");
    cyc(4'b1100, 0, 0, "R4 fixed after change");
    check("R4 master2", grant, 4'b0100);
    cyc(4'b1000, 0, 0, "R6 release");
    cyc(4'b1000, 0, 1, "R4 pick");
    cyc(4'b0000, 0, 1, "R5 release");

    for (int i = 0; i < 400; i++) begin
      logic [N-1:0] r;
      r = N'($urandom);
      cyc(r, ($urandom % 4) == 0, ($urandom % 8) < 5, "R2 R3 R4 R5 R6 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule